// File: doc/BRIEF.md
# Fault Supervisor With Auto-Restart

This block is the digital protection manager of a switching power controller. It takes already-synchronised comparator flags for seven fault conditions. It also takes a strobe for each switching period and a pulse that marks each gate turn-on. From these inputs it decides when a fault is real. Some conditions are qualified over several switching periods and overload is qualified over a long blanking interval. The rest take effect in the cycle they are seen.

When a fault is qualified, the gate is disabled and a code for that fault is latched. The block then waits a restart delay and runs a startup phase with the gate enabled. At the end of that phase it checks the fault flags again. If every flag is clear, normal running resumes and the code is cleared. Otherwise a new delay begins.

The same startup phase runs after reset. The analog thresholds, the sensing circuits and the gate driver belong to other blocks.

Top module: `fault_supervisor`

## Requirements
- R1: After reset the block is in its startup phase with `gate_en` = 1 and `fault_code` = 0. If no flag is set at the end of `RESTART_TICKS` clocks, it enters normal running.
- R2: While running, `vdd_ov` sampled high on `OV_CYCLES` consecutive `cyc_tick` strobes gives code 1. Any clock with `vdd_ov` low sets the count back to zero.
- R3: While running, `IDLE_CYCLES` `cyc_tick` strobes with no `gate_pulse` gives code 3. A `gate_pulse` sets the count back to zero.
- R4: While running, `overload` high for `OLP_TICKS` consecutive clocks gives code 4. Any gap sets the interval back to zero.
- R5: While running, these flags act in the cycle they are seen: `sense_ov` gives code 2, `out_short` code 5, `cs_open` code 6, `line_low` code 7 and `vdd_uv` code 8. `gate_en` is low on the next clock.
- R6: When several faults qualify on the same clock, the smallest code is latched.
- R7: After a fault, `gate_en` stays low for exactly `DELAY_TICKS` clocks. It is then high for the `RESTART_TICKS` clocks of the startup phase.
- R8: At the last clock of the startup phase, a high level on any of the seven flags starts a new delay and keeps the code. With all flags low, normal running resumes and `fault_code` becomes 0.
- R9: `fault_code` keeps the fault that started the sequence, through the delay, the startup phase and failed rechecks. A later flag does not replace it.
- R10: During the delay, and before the last clock of the startup phase, the flags do not change `gate_en` or `fault_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | One-clock strobe per switching period |
| gate_pulse | input | 1 | One-clock pulse per gate turn-on |
| vdd_ov | input | 1 | Supply overvoltage comparator |
| sense_ov | input | 1 | Auxiliary sense overvoltage comparator |
| out_short | input | 1 | Output short (sense voltage too low) |
| overload | input | 1 | Peak current at limit or feedback at overload level |
| cs_open | input | 1 | Current-sense path open |
| line_low | input | 1 | Line brown-out |
| vdd_uv | input | 1 | Supply undervoltage |
| gate_en | output | 1 | Gate enable; low during the restart delay |
| fault_code | output | 4 | Latched first fault code, 0 while running |

## Verification
The five immediate flags are applied one at a time from a vector table, and also in pairs. Single flags show that each flag maps to its own code. The pairs show which code wins on the same clock.

The counted faults are each driven to one clock or one strobe short of their limit, both with and without a gap. This separates true consecutive qualification from plain accumulation.

A flag held across the recheck proves that the retry loop repeats. A second flag raised during the delay shows that the first code is kept. A brief flag during the startup phase shows that only its final clock is judged.

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int OV_CYCLES     = 4,
  parameter int IDLE_CYCLES   = 4,
  parameter int OLP_TICKS     = 40000,
  parameter int DELAY_TICKS   = 2048,
  parameter int RESTART_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_tick,
  input  logic       gate_pulse,
  input  logic       vdd_ov,
  input  logic       sense_ov,
  input  logic       out_short,
  input  logic       overload,
  input  logic       cs_open,
  input  logic       line_low,
  input  logic       vdd_uv,
  output logic       gate_en,
  output logic [3:0] fault_code
);
  localparam int OVW  = $clog2(OV_CYCLES + 1);
  localparam int IDW  = $clog2(IDLE_CYCLES + 1);
  localparam int OLW  = $clog2(OLP_TICKS + 1);
  localparam int TMAX = (DELAY_TICKS > RESTART_TICKS) ? DELAY_TICKS : RESTART_TICKS;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {ST_RUN, ST_HOLD, ST_RESTART} st_t;

  st_t            state;
  logic [TW-1:0]  tmr;
  logic [OVW-1:0] ov_cnt;
  logic [IDW-1:0] idle_cnt;
  logic [OLW-1:0] olp_cnt;
  logic           in_run, ov_hit, idle_hit, olp_hit, any_flag;
  logic [3:0]     hit_code;

  assign in_run   = (state == ST_RUN);
  assign gate_en  = (state != ST_HOLD);
  assign any_flag = vdd_ov | sense_ov | out_short | overload | cs_open | line_low | vdd_uv;

  assign ov_hit   = vdd_ov && cyc_tick && (ov_cnt == OVW'(OV_CYCLES - 1));
  assign idle_hit = cyc_tick && !gate_pulse && (idle_cnt == IDW'(IDLE_CYCLES - 1));
  assign olp_hit  = overload && (olp_cnt == OLW'(OLP_TICKS - 1));

  always_comb begin
    hit_code = 4'd0;
    if (in_run) begin
      if (ov_hit)         hit_code = 4'd1;
      else if (sense_ov)  hit_code = 4'd2;
      else if (idle_hit)  hit_code = 4'd3;
      else if (olp_hit)   hit_code = 4'd4;
      else if (out_short) hit_code = 4'd5;
      else if (cs_open)   hit_code = 4'd6;
      else if (line_low)  hit_code = 4'd7;
      else if (vdd_uv)    hit_code = 4'd8;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_cnt   <= '0;
      idle_cnt <= '0;
      olp_cnt  <= '0;
    end else begin
      if (!in_run || !vdd_ov)  ov_cnt <= '0;
      else if (cyc_tick)       ov_cnt <= ov_cnt + 1'b1;

      if (!in_run || gate_pulse) idle_cnt <= '0;
      else if (cyc_tick)         idle_cnt <= idle_cnt + 1'b1;

      if (!in_run || !overload) olp_cnt <= '0;
      else                      olp_cnt <= olp_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RESTART;
      tmr        <= '0;
      fault_code <= 4'd0;
    end else begin
      case (state)
        ST_RUN: begin
          if (hit_code != 4'd0) begin
            state      <= ST_HOLD;
            tmr        <= '0;
            fault_code <= hit_code;
          end
        end
        ST_HOLD: begin
          if (tmr == TW'(DELAY_TICKS - 1)) begin
            state <= ST_RESTART;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          if (tmr == TW'(RESTART_TICKS - 1)) begin
            tmr <= '0;
            if (any_flag) begin
              state <= ST_HOLD;
            end else begin
              state      <= ST_RUN;
              fault_code <= 4'd0;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_run,
  input logic       gate_en,
  input logic [3:0] fault_code,
  input logic       sense_ov,
  input logic       out_short,
  input logic       cs_open,
  input logic       line_low,
  input logic       vdd_uv,
  input logic       overload
);
  a_r5_immediate_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && (sense_ov || out_short || cs_open || line_low || vdd_uv)) |=> !gate_en);

  a_r1_run_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> (fault_code == 4'd0));

  a_r9_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 4'd0) |=> ((fault_code == $past(fault_code)) || (fault_code == 4'd0)));

  a_r7_gate_off_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> (fault_code != 4'd0));

  a_r6_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    fault_code <= 4'd8);

  a_r4_overload_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_en) && fault_code == 4'd4) |-> $past(overload));
endmodule

bind fault_supervisor fault_supervisor_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_run(in_run), .gate_en(gate_en),
  .fault_code(fault_code), .sense_ov(sense_ov), .out_short(out_short),
  .cs_open(cs_open), .line_low(line_low), .vdd_uv(vdd_uv), .overload(overload)
);

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
  localparam int PERIOD = 10;
  localparam int OVC = 4, IDC = 4, OLP = 20, DLY = 8, RST = 6;

  // {sense_ov, out_short, cs_open, line_low, vdd_uv}, expected code
  localparam logic [8:0] VEC [7] = '{
    {5'b10000, 4'd2}, {5'b01000, 4'd5}, {5'b00100, 4'd6}, {5'b00010, 4'd7},
    {5'b00001, 4'd8}, {5'b10100, 4'd2}, {5'b01011, 4'd5}
  };

  logic clk = 0, rst_n = 0;
  logic cyc_tick = 0, gate_pulse = 0, pulses_en = 1;
  logic vdd_ov = 0, sense_ov = 0, out_short = 0, overload = 0;
  logic cs_open = 0, line_low = 0, vdd_uv = 0;
  logic gate_en;
  logic [3:0] fault_code;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  fault_supervisor #(.OV_CYCLES(OVC), .IDLE_CYCLES(IDC), .OLP_TICKS(OLP),
                     .DELAY_TICKS(DLY), .RESTART_TICKS(RST)) i_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .gate_pulse(gate_pulse),
    .vdd_ov(vdd_ov), .sense_ov(sense_ov), .out_short(out_short), .overload(overload),
    .cs_open(cs_open), .line_low(line_low), .vdd_uv(vdd_uv),
    .gate_en(gate_en), .fault_code(fault_code));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic tick);
    cyc_tick   = tick;
    gate_pulse = tick && pulses_en;
    @(negedge clk);
    cyc_tick   = 0;
    gate_pulse = 0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step(0);
  endtask

  task automatic period();
    step(0); step(0); step(0); step(1);
  endtask

  task automatic recover(input string req);
    steps(DLY + RST);
    chk({req, " resume gate"}, gate_en, 1);
    chk({req, " resume code"}, fault_code, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset gate_en", gate_en, 1);
    chk("R1 reset fault_code", fault_code, 0);
    rst_n = 1;
    step(0);
    cs_open = 1; step(0); cs_open = 0;
    steps(RST - 2);
    chk("R10 flag in startup ignored gate", gate_en, 1);
    chk("R1 startup ends in run code", fault_code, 0);
    vdd_uv = 1; step(0); vdd_uv = 0;
    chk("R1 running after startup", gate_en, 0);
    recover("R1");

    for (int v = 0; v < 7; v++) begin
      {sense_ov, out_short, cs_open, line_low, vdd_uv} = VEC[v][8:4];
      step(0);
      {sense_ov, out_short, cs_open, line_low, vdd_uv} = 5'b0;
      chk("R5 gate off", gate_en, 0);
      chk("R5/R6 code", fault_code, int'(VEC[v][3:0]));
      steps(DLY - 1);
      chk("R7 still off at delay end", gate_en, 0);
      step(0);
      chk("R7 startup gate on", gate_en, 1);
      steps(RST - 1);
      chk("R9 code held in startup", fault_code, int'(VEC[v][3:0]));
      step(0);
      chk("R8 code cleared", fault_code, 0);
      chk("R8 gate on", gate_en, 1);
    end

    vdd_ov = 1;
    repeat (OVC - 1) period();
    chk("R2 below count", gate_en, 1);
    vdd_ov = 0; step(0); vdd_ov = 1;
    repeat (OVC - 1) period();
    chk("R2 gap restarts count", gate_en, 1);
    period();
    chk("R2 ov gate off", gate_en, 0);
    chk("R2 ov code", fault_code, 1);
    vdd_ov = 0;
    recover("R2");

    pulses_en = 0;
    repeat (IDC - 1) period();
    chk("R3 below idle count", gate_en, 1);
    period();
    chk("R3 idle code", fault_code, 3);
    pulses_en = 1;
    recover("R3");
    repeat (IDC + 2) period();
    chk("R3 pulses keep running", gate_en, 1);

    overload = 1; steps(OLP - 1);
    chk("R4 below blanking", gate_en, 1);
    overload = 0; step(0); overload = 1; steps(OLP - 1);
    chk("R4 gap restarts blanking", gate_en, 1);
    step(0);
    chk("R4 overload gate off", gate_en, 0);
    chk("R4 overload code", fault_code, 4);
    overload = 0;
    recover("R4");

    line_low = 1; step(0);
    chk("R5 brown-out code", fault_code, 7);
    steps(DLY + RST);
    chk("R8 failed recheck gate off", gate_en, 0);
    chk("R8 failed recheck code", fault_code, 7);
    line_low = 0;
    steps(DLY);
    chk("R8 second startup gate on", gate_en, 1);
    steps(RST);
    chk("R8 second recheck clears", fault_code, 0);

    vdd_uv = 1; step(0); vdd_uv = 0;
    sense_ov = 1; steps(2); sense_ov = 0;
    chk("R9 first fault kept", fault_code, 8);
    chk("R10 flag in delay no effect", gate_en, 0);
    recover("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule